// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

An 8-bit arithmetic and logic unit that combines an accumulator value with a second operand under a 4-bit operation code. It produces an 8-bit result and a byte of five condition flags: sign, zero, auxiliary carry, even parity and carry. The operations are binary add and subtract, each with or without the incoming carry; AND, OR, XOR and compare; increment and decrement; complement; four accumulator rotates; and a decimal-adjust step that restores two packed BCD digits after a binary addition.

The result path is purely combinational. The flag byte is either registered, so that it appears one clock after the operands, or passed straight through, depending on a parameter. The incoming carry and auxiliary carry are inputs, so the surrounding datapath owns the flag register and decides when to load it. Operations that keep a flag pass the matching input through.

Top module: `acc_alu`

## Requirements
- R1: Operation 0 (add) gives acc+opd and operation 1 (add with carry) gives acc+opd+cy_i, modulo 256. The carry flag is set when the true sum exceeds 255.
- R2: Operation 2 (subtract) gives acc-opd and operation 3 (subtract with borrow) gives acc-opd-cy_i, modulo 256. The carry flag is set when a borrow is needed, that is when the subtrahend is larger than acc.
- R3: Operation 7 (compare) returns acc unchanged on the result. Its flags are those operation 2 would give for the same operands.
- R4: The zero flag (bit 6) is set exactly when the flagged value is 00h. The flagged value is the result, or the difference in the case of a compare.
- R5: The sign flag (bit 7) equals bit 7 of the flagged value.
- R6: The parity flag (bit 2) is set when the flagged value holds an even number of ones.
- R7: The auxiliary carry flag (bit 4) is set when adding the low nibbles carries into bit 4. For operations 2, 3 and 7 it is set when the low nibble needs a borrow.
- R8: Operations 4 (AND), 5 (XOR) and 6 (OR) clear the carry flag. AND sets auxiliary carry, and OR and XOR clear it. XOR of a value with itself gives 00h.
- R9: Operations 8 (increment) and 9 (decrement) change acc by one modulo 256. They update auxiliary carry, but the carry flag copies cy_i.
- R10: Operations 11, 12, 13 and 14 rotate acc left, right, left through carry and right through carry. The plain forms wrap the end bit and copy it into carry. The through-carry forms shift cy_i in and the end bit out to carry.
- R11: Operation 10 (complement) returns the bitwise inverse of acc and copies cy_i to carry. Operation 10 and the rotates copy ac_i to auxiliary carry.
- R12: Operation 15 (decimal adjust) adds 06h when the low nibble of acc exceeds 9 or ac_i is set. It adds 60h when acc exceeds 99h or cy_i is set, and carry is set in exactly that case. Auxiliary carry is the carry out of the low nibble of this addition.
- R13: In the flag byte, bits 5 and 3 read 0 and bit 1 reads 1. With registered flags, flags_o shows the flags of the operands present one clock earlier and reads 02h while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| res_o | output | 8 | Result, combinational |
| flags_o | output | 8 | Flag byte, registered by default |

## Verification
The only stored state is the flag register. A wrong value there shows on flags_o one clock after the operands that caused it, and it is replaced on the next clock. A wrong operand mux or carry-in selection appears in res_o immediately. Corner values decide most faults: nibble boundaries such as 0Fh/10h and 00h/FFh for auxiliary carry, operand pairs that give exactly 00h or a borrow, and decimal-adjust inputs on either side of 9 and 99h. A scoreboard checks every operation code against values computed from the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int DW  = 8;
   localparam int NIB = 4;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
      OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
      OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_CPL = 4'd10, OP_RLC = 4'd11,
      OP_RRC = 4'd12, OP_RAL = 4'd13, OP_RAR = 4'd14, OP_DAA = 4'd15
   } alu_op_e;

   localparam int FB_S  = 7;
   localparam int FB_Z  = 6;
   localparam int FB_AC = 4;
   localparam int FB_P  = 2;
   localparam int FB_CY = 0;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
(
   input  alu_op_e         op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic            cin,
   output logic [DW-1:0]   sum,
   output logic            cy,
   output logic            ac
);
   logic [DW-1:0] bsel;
   logic          cin_eff;
   logic          sub_mode;
   logic [DW:0]   full;
   logic [NIB:0]  nib;

   always_comb begin
      bsel     = b;
      cin_eff  = 1'b0;
      sub_mode = 1'b0;
      case (op)
         OP_ADC: cin_eff = cin;
         OP_SUB, OP_CMP: begin
            bsel = ~b; cin_eff = 1'b1; sub_mode = 1'b1;
         end
         OP_SBB: begin
            bsel = ~b; cin_eff = ~cin; sub_mode = 1'b1;
         end
         OP_INC: begin
            bsel = '0; cin_eff = 1'b1;
         end
         OP_DEC: begin
            bsel = '1; sub_mode = 1'b1;
         end
         default: ;
      endcase
   end

   assign full = {1'b0, a} + {1'b0, bsel} + {{DW{1'b0}}, cin_eff};
   assign nib  = {1'b0, a[NIB-1:0]} + {1'b0, bsel[NIB-1:0]} + {{NIB{1'b0}}, cin_eff};
   assign sum  = full[DW-1:0];
   assign cy   = sub_mode ? ~full[DW] : full[DW];
   assign ac   = sub_mode ? ~nib[NIB] : nib[NIB];
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
   import acc_alu_pkg::*;
(
   input  alu_op_e         op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic            cin,
   output logic [DW-1:0]   res,
   output logic            cy
);
   always_comb begin
      res = a;
      cy  = cin;
      case (op)
         OP_AND: begin res = a & b; cy = 1'b0; end
         OP_XOR: begin res = a ^ b; cy = 1'b0; end
         OP_OR:  begin res = a | b; cy = 1'b0; end
         OP_CPL: res = ~a;
         OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy = a[DW-1]; end
         OP_RRC: begin res = {a[0], a[DW-1:1]};    cy = a[0];    end
         OP_RAL: begin res = {a[DW-2:0], cin};     cy = a[DW-1]; end
         OP_RAR: begin res = {cin, a[DW-1:1]};     cy = a[0];    end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_bcd_adj.sv
module acc_alu_bcd_adj
   import acc_alu_pkg::*;
(
   input  logic [DW-1:0] a,
   input  logic          cin,
   input  logic          acin,
   output logic [DW-1:0] res,
   output logic          cy,
   output logic          ac
);
   localparam logic [NIB-1:0] MAXD = NIB'(9);
   localparam logic [DW-1:0]  MAXB = {MAXD, MAXD};

   logic          fix_lo, fix_hi;
   logic [DW-1:0] corr;
   logic [NIB:0]  lo_sum;

   assign fix_lo = (a[NIB-1:0] > MAXD) | acin;
   assign fix_hi = (a > MAXB) | cin;
   assign corr   = {fix_hi ? NIB'(6) : NIB'(0), fix_lo ? NIB'(6) : NIB'(0)};
   assign lo_sum = {1'b0, a[NIB-1:0]} + {1'b0, corr[NIB-1:0]};
   assign res    = a + corr;
   assign cy     = fix_hi;
   assign ac     = lo_sum[NIB];
endmodule

// File: rtl/acc_alu_flag_pack.sv
module acc_alu_flag_pack
   import acc_alu_pkg::*;
#(
   parameter bit FIX5 = 1'b0,
   parameter bit FIX3 = 1'b0,
   parameter bit FIX1 = 1'b1
)(
   input  logic [DW-1:0] val,
   input  logic          cy,
   input  logic          ac,
   output logic [7:0]    flags
);
   always_comb begin
      flags        = {FIX1 ? 8'h00 : 8'h00} | {2'b00, FIX5, 1'b0, FIX3, 1'b0, FIX1, 1'b0};
      flags[FB_S]  = val[DW-1];
      flags[FB_Z]  = (val == '0);
      flags[FB_AC] = ac;
      flags[FB_P]  = ~(^val);
      flags[FB_CY] = cy;
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int REG_FLAGS = 1,
   parameter bit FIX5      = 1'b0,
   parameter bit FIX3      = 1'b0,
   parameter bit FIX1      = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_i,
   input  logic [7:0]    acc_i,
   input  logic [7:0]    opd_i,
   input  logic          cy_i,
   input  logic          ac_i,
   output logic [7:0]    res_o,
   output logic [7:0]    flags_o
);
   localparam logic [7:0] FLAG_RST = {2'b00, FIX5, 1'b0, FIX3, 1'b0, FIX1, 1'b0};

   if (REG_FLAGS != 0 && REG_FLAGS != 1) begin : g_bad_reg
      $error("acc_alu: REG_FLAGS must be 0 or 1");
   end
   if (DW != 2 * NIB) begin : g_bad_width
      $error("acc_alu: decimal adjust needs exactly two digits");
   end

   alu_op_e       op;
   logic [DW-1:0] ar_sum, bo_res, bcd_res, flag_val;
   logic          ar_cy, ar_ac, bo_cy, bcd_cy, bcd_ac;
   logic          f_cy, f_ac;
   logic [7:0]    flags_c;

   assign op = alu_op_e'(op_i);

   acc_alu_arith u_arith (
      .op(op), .a(acc_i), .b(opd_i), .cin(cy_i),
      .sum(ar_sum), .cy(ar_cy), .ac(ar_ac)
   );

   acc_alu_bitops u_bitops (
      .op(op), .a(acc_i), .b(opd_i), .cin(cy_i),
      .res(bo_res), .cy(bo_cy)
   );

   acc_alu_bcd_adj u_bcd (
      .a(acc_i), .cin(cy_i), .acin(ac_i),
      .res(bcd_res), .cy(bcd_cy), .ac(bcd_ac)
   );

   always_comb begin
      res_o    = ar_sum;
      flag_val = ar_sum;
      f_cy     = ar_cy;
      f_ac     = ar_ac;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: ;
         OP_CMP: res_o = acc_i;
         OP_INC, OP_DEC: f_cy = cy_i;
         OP_AND, OP_XOR, OP_OR: begin
            res_o = bo_res; flag_val = bo_res; f_cy = bo_cy;
            f_ac  = (op == OP_AND);
         end
         OP_DAA: begin
            res_o = bcd_res; flag_val = bcd_res; f_cy = bcd_cy; f_ac = bcd_ac;
         end
         default: begin
            res_o = bo_res; flag_val = bo_res; f_cy = bo_cy; f_ac = ac_i;
         end
      endcase
   end

   acc_alu_flag_pack #(.FIX5(FIX5), .FIX3(FIX3), .FIX1(FIX1)) u_flags (
      .val(flag_val), .cy(f_cy), .ac(f_ac), .flags(flags_c)
   );

   if (REG_FLAGS == 1) begin : g_reg
      logic [7:0] flags_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q <= FLAG_RST;
         else        flags_q <= flags_c;
      end
      assign flags_o = flags_q;
   end else begin : g_comb
      assign flags_o = flags_c;
   end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int REG_FLAGS = 1
)(
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] op_i,
   input logic [7:0] acc_i,
   input logic       cy_i,
   input logic [7:0] res_o,
   input logic [7:0] flags_o,
   input logic [7:0] flags_c
);
   logic not_cmp;
   assign not_cmp = (op_i != 4'd7);

   // R4
   p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      not_cmp |-> (flags_c[6] == (res_o == 8'h00)));
   // R5
   p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      not_cmp |-> (flags_c[7] == res_o[7]));
   // R6
   p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
      not_cmp |-> (flags_c[2] == ($countones(res_o) % 2 == 0)));
   // R3
   p_cmp_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd7) |-> (res_o == acc_i));
   // R8
   p_logic_cy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i inside {4'd4, 4'd5, 4'd6}) |-> !flags_c[0]);
   // R9
   p_incdec_cy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i inside {4'd8, 4'd9}) |-> (flags_c[0] == cy_i));
   // R13
   p_fixed_bits_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b1));

   if (REG_FLAGS == 1) begin : g_reg_chk
      // R13
      p_flag_delay_r13: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (flags_o == $past(flags_c)));
   end
endmodule

bind acc_alu acc_alu_chk #(.REG_FLAGS(REG_FLAGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .cy_i(cy_i),
   .res_o(res_o), .flags_o(flags_o), .flags_c(flags_c)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic [7:0] acc_i = '0, opd_i = '0;
   logic       cy_i = 1'b0, ac_i = 1'b0;
   logic [7:0] res_o, flags_o;

   int total = 0;
   int bad   = 0;
   bit vld   = 1'b0;
   bit done  = 1'b0;

   typedef struct {
      logic [7:0] res;
      logic [7:0] flg;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   acc_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
      .cy_i(cy_i), .ac_i(ac_i), .res_o(res_o), .flags_o(flags_o)
   );

   function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [7:0] b, input logic c, input logic acn);
      exp_t e;
      int ai, bi, ci, t;
      logic [7:0] fv;
      logic cy, ac;
      ai = int'(a); bi = int'(b); ci = c ? 1 : 0;
      cy = c; ac = acn; t = ai;
      case (op)
         4'd0:  begin t = ai + bi;      cy = t > 255; ac = (ai % 16 + bi % 16) > 15; end
         4'd1:  begin t = ai + bi + ci; cy = t > 255; ac = (ai % 16 + bi % 16 + ci) > 15; end
         4'd2, 4'd7: begin t = ai - bi; cy = ai < bi; ac = (ai % 16) < (bi % 16); end
         4'd3:  begin t = ai - bi - ci; cy = ai < bi + ci; ac = (ai % 16) < (bi % 16 + ci); end
         4'd4:  begin t = int'(a & b); cy = 0; ac = 1; end
         4'd5:  begin t = int'(a ^ b); cy = 0; ac = 0; end
         4'd6:  begin t = int'(a | b); cy = 0; ac = 0; end
         4'd8:  begin t = ai + 1; ac = (ai % 16) == 15; end
         4'd9:  begin t = ai - 1; ac = (ai % 16) == 0; end
         4'd10: t = 255 - ai;
         4'd11: begin t = (ai * 2) % 256 + ai / 128; cy = a[7]; end
         4'd12: begin t = ai / 2 + (ai % 2) * 128; cy = a[0]; end
         4'd13: begin t = (ai * 2) % 256 + ci; cy = a[7]; end
         4'd14: begin t = ai / 2 + ci * 128; cy = a[0]; end
         default: begin
            int corr;
            corr = 0;
            if ((ai % 16) > 9 || acn) corr = corr + 6;
            cy = (ai > 153) || c;
            if (cy) corr = corr + 96;
            ac = (ai % 16 + corr % 16) > 15;
            t  = ai + corr;
         end
      endcase
      t  = ((t % 256) + 256) % 256;
      fv = 8'(t);
      e.res = (op == 4'd7) ? a : fv;
      e.flg = {fv[7], fv == 8'h00, 1'b0, ac, 1'b0, ~(^fv), 1'b1, cy};
      e.tag = "";
      return e;
   endfunction

   task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic acn, input string tag);
      exp_t e;
      @(negedge clk);
      op_i = op; acc_i = a; opd_i = b; cy_i = c; ac_i = acn;
      e = model(op, a, b, c, acn);
      e.tag = tag;
      sb.push_back(e);
      vld = 1'b1;
   endtask

   // monitor: results appear at the edge after the driving negedge
   always @(posedge clk) begin
      #1;
      if (vld && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (res_o !== e.res || flags_o !== e.flg) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h: res=%h flags=%h expected res=%h flags=%h",
                     e.tag, op_i, acc_i, opd_i, res_o, flags_o, e.res, e.flg);
         end
      end
   end

   initial begin
      #50_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;   // R13 reset value
      if (flags_o !== 8'h02) begin
         bad++; $display("FAIL R13 reset flags=%h expected=02", flags_o);
      end
      rst_n = 1'b1;

      drive(4'd0, 8'h3A, 8'h46, 0, 0, "R1 add");
      drive(4'd0, 8'hFF, 8'h01, 0, 0, "R1 add wrap R4");
      drive(4'd1, 8'h7F, 8'h00, 1, 0, "R1 adc R5");
      drive(4'd1, 8'h80, 8'h7F, 1, 0, "R1 adc carry");
      drive(4'd2, 8'h10, 8'h01, 0, 0, "R2 sub R7");
      drive(4'd2, 8'h05, 8'h06, 0, 0, "R2 sub borrow");
      drive(4'd3, 8'h05, 8'h05, 1, 0, "R2 sbb");
      drive(4'd3, 8'h20, 8'h0F, 1, 1, "R2 sbb nib");
      drive(4'd7, 8'h42, 8'h42, 0, 0, "R3 cmp equal");
      drive(4'd7, 8'h10, 8'h20, 0, 0, "R3 cmp less");
      drive(4'd0, 8'h0F, 8'h01, 0, 0, "R7 nibble carry");
      drive(4'd0, 8'h03, 8'h00, 0, 0, "R6 parity even");
      drive(4'd0, 8'h07, 8'h00, 0, 0, "R6 parity odd");
      drive(4'd4, 8'hF0, 8'h3C, 1, 0, "R8 and");
      drive(4'd5, 8'h9B, 8'h9B, 1, 1, "R8 xor self");
      drive(4'd6, 8'h00, 8'h00, 1, 1, "R8 or zero");
      drive(4'd8, 8'h0F, 8'h00, 1, 0, "R9 inc nibble");
      drive(4'd8, 8'hFF, 8'h00, 0, 0, "R9 inc wrap");
      drive(4'd9, 8'h00, 8'h00, 1, 0, "R9 dec wrap");
      drive(4'd9, 8'h01, 8'h00, 0, 1, "R9 dec zero");
      drive(4'd11, 8'h81, 8'h00, 0, 0, "R10 rlc");
      drive(4'd12, 8'h81, 8'h00, 0, 0, "R10 rrc");
      drive(4'd13, 8'h80, 8'h00, 1, 0, "R10 ral");
      drive(4'd14, 8'h01, 8'h00, 0, 1, "R10 rar R11");
      drive(4'd10, 8'h5A, 8'h00, 1, 1, "R11 cpl");
      drive(4'd10, 8'hFF, 8'h00, 0, 0, "R11 cpl zero");
      drive(4'd15, 8'h9B, 8'h00, 0, 0, "R12 daa both");
      drive(4'd15, 8'h15, 8'h00, 0, 1, "R12 daa ac in");
      drive(4'd15, 8'h99, 8'h00, 0, 0, "R12 daa none");
      drive(4'd15, 8'h12, 8'h00, 1, 0, "R12 daa cy in");
      drive(4'd15, 8'h9A, 8'h00, 0, 0, "R12 daa 9A");

      for (int op = 0; op < 16; op++) begin
         for (int k = 0; k < 8; k++) begin
            drive(4'(op), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                  "R13 sweep");
         end
      end

      @(negedge clk);
      vld = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule